// File: doc/BRIEF.md
# Synchronous Fault Capture Register

This block sits beside a processor's memory interface and records why, and where, a synchronous memory access failed. Every cycle it may see a fault strobe carrying one or more cause flags: invalid mapping, protection violation, timeout, bus error, memory error, size error and watchdog. The strobe also carries the virtual address of the failing access, whether it was a write, and whether it was an instruction fetch or a data access. Any recorded cause raises a memory-exception line toward the core.

Prefetch can fault before the load or store that actually traps. To cope with this, cause flags pile up until software reads them, and the read clears them. The address register favours data accesses. Once a data-access fault is latched, later instruction-fetch faults leave it alone until the next status read. The direction flag always moves together with the address, so both describe the same cycle.

Software reaches the block through a small register port. A one-bit select picks the status word or the address word. A read returns the value one cycle later. A write to the status word loads it for diagnostic use.

Top module: `sync_fault_capture`

## Requirements
- R1: The status word places the direction flag at bit 15 (1 = write), invalid mapping at bit 7, protection at bit 6, timeout at bit 5, bus error at bit 4, memory error at bit 3, size error at bit 1 and watchdog at bit 0. Input `flt_cause` bits [6:0] map in that cause order: [6] invalid, [5] protection, [4] timeout, [3] bus, [2] memory, [1] size, [0] watchdog.
- R2: `mem_exc` is high in the cycle after a fault strobe with at least one cause bit set. It is low once the status word holds no cause bits.
- R3: Cause bits OR-accumulate across successive faults until the status word is read.
- R4: A read with `reg_sel`=0 (status) returns the word in `reg_rdata` one clock later and clears the status word at the same edge.
- R5: After a data-access fault, an instruction-fetch fault does not change the address word until the status word is read.
- R6: Each data-access fault overwrites the address word, so it holds the most recent data-access fault address.
- R7: If only instruction-fetch faults have occurred since the last status read, the address word holds the most recent one.
- R8: The direction flag is loaded in the same cycle as the address word, from the same fault.
- R9: A write with `reg_sel`=0 loads the status word's cause and direction bits from `reg_wdata`. A write with `reg_sel`=1 (address) has no effect.
- R10: A fault arriving in the same cycle as a status read is kept. It appears on the next status read, and its address is latched.
- R11: Unused status bits (14..8 and 2) and all bits above 15 read as zero, including after a diagnostic write that sets them.
- R12: After reset the status word and the address word are zero and `mem_exc` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flt_valid | input | 1 | Fault strobe for this cycle |
| flt_cause | input | 7 | Cause flags, order given in R1 |
| flt_addr | input | ADDR_W | Virtual address of the faulting cycle |
| flt_write | input | 1 | 1 when the faulting cycle was a write |
| flt_ifetch | input | 1 | 1 for instruction fetch, 0 for data access |
| reg_rd | input | 1 | Register read request |
| reg_wr | input | 1 | Register write request |
| reg_sel | input | 1 | 0 = status word, 1 = address word |
| reg_wdata | input | ADDR_W | Write data |
| reg_rdata | output | ADDR_W | Read data, valid the cycle after `reg_rd` |
| mem_exc | output | 1 | Memory exception toward the processor |

## Verification
The bench builds the block with its default ADDR_W of 32. It uses addresses that set the top bits, so a truncated address path or a status word leaking into the upper half of the read data shows up. With this width, a diagnostic write of all ones can reach every unused status bit. Directed sequences cover fetch-then-data, data-then-fetch, fetch-only and read-colliding-with-fault orderings, where the address priority rule decides the result.

// File: rtl/sfc_pkg.sv
package sfc_pkg;

    localparam int STAT_W  = 16;
    localparam int DIR_POS = 15;
    localparam int CAUSE_W = 7;

    typedef struct packed {
        logic invalid;
        logic prot;
        logic timeout;
        logic buserr;
        logic memerr;
        logic sizeerr;
        logic watchdog;
    } cause_t;

    typedef enum logic {
        SEL_STATUS = 1'b0,
        SEL_ADDR   = 1'b1
    } sel_e;

    function automatic logic [STAT_W-1:0] pack_status(cause_t c, logic dir);
        logic [STAT_W-1:0] s;
        s          = '0;
        s[DIR_POS] = dir;
        s[7]       = c.invalid;
        s[6]       = c.prot;
        s[5]       = c.timeout;
        s[4]       = c.buserr;
        s[3]       = c.memerr;
        s[1]       = c.sizeerr;
        s[0]       = c.watchdog;
        return s;
    endfunction

    function automatic cause_t unpack_causes(logic [STAT_W-1:0] w);
        cause_t c;
        c.invalid  = w[7];
        c.prot     = w[6];
        c.timeout  = w[5];
        c.buserr   = w[4];
        c.memerr   = w[3];
        c.sizeerr  = w[1];
        c.watchdog = w[0];
        return c;
    endfunction

    function automatic logic fault_hit(logic v, cause_t c);
        return v && (c != '0);
    endfunction

endpackage

// File: rtl/sfc_cause_acc.sv
module sfc_cause_acc
    import sfc_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   hit,
    input  cause_t cause_in,
    input  logic   clr,
    input  logic   wr_en,
    input  cause_t wr_causes,
    output cause_t causes_q
);

    cause_t incoming;
    cause_t causes_d;

    always_comb begin
        incoming = hit ? cause_in : cause_t'('0);
        if (wr_en)
            causes_d = wr_causes | incoming;
        else if (clr)
            causes_d = incoming;
        else
            causes_d = causes_q | incoming;
    end

    always_ff @(posedge clk) begin
        if (rst)
            causes_q <= '0;
        else
            causes_q <= causes_d;
    end

    // R3: without a read or write, no set bit ever drops
    a_r3_accumulate: assert property (@(posedge clk) disable iff (rst)
        (!clr && !wr_en) |=> ((causes_q & $past(causes_q)) == $past(causes_q)));

    // R4: a read with no colliding fault empties the causes
    a_r4_clear_on_read: assert property (@(posedge clk) disable iff (rst)
        (clr && !hit && !wr_en) |=> (causes_q == '0));

    // R10: a fault colliding with a read survives as the only content
    a_r10_collide_kept: assert property (@(posedge clk) disable iff (rst)
        (clr && hit && !wr_en) |=> (causes_q == $past(cause_in)));

endmodule

// File: rtl/sfc_addr_latch.sv
module sfc_addr_latch #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hit,
    input  logic              ifetch,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              write_in,
    input  logic              clr,
    input  logic              wr_dir_en,
    input  logic              wr_dir,
    output logic [ADDR_W-1:0] addr_q,
    output logic              dir_q
);

    logic held_q;
    logic held_eff;
    logic take;
    logic data_hit;

    always_comb begin
        held_eff = clr ? 1'b0 : held_q;
        data_hit = hit && !ifetch;
        take     = hit && (!ifetch || !held_eff);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            dir_q  <= 1'b0;
            held_q <= 1'b0;
        end else begin
            held_q <= held_eff | data_hit;
            if (take) begin
                addr_q <= addr_in;
                dir_q  <= write_in;
            end else if (wr_dir_en) begin
                dir_q  <= wr_dir;
            end else if (clr) begin
                dir_q  <= 1'b0;
            end
        end
    end

    // R5: a latched data fault is shielded from fetch faults until a read
    a_r5_fetch_no_overwrite: assert property (@(posedge clk) disable iff (rst)
        (held_q && !clr && hit && ifetch) |=> $stable(addr_q));

    // R6: every data fault lands in the address register
    a_r6_data_latches: assert property (@(posedge clk) disable iff (rst)
        data_hit |=> (addr_q == $past(addr_in)));

endmodule

// File: rtl/sfc_regport.sv
module sfc_regport
    import sfc_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd,
    input  sel_e              sel,
    input  logic [STAT_W-1:0] status_word,
    input  logic [ADDR_W-1:0] addr_word,
    output logic [ADDR_W-1:0] rdata_q
);

    localparam int PAD_W = ADDR_W - STAT_W;

    logic [ADDR_W-1:0] status_ext;

    generate
        if (PAD_W > 0) begin : g_pad
            assign status_ext = {{PAD_W{1'b0}}, status_word};
        end else begin : g_nopad
            assign status_ext = status_word[ADDR_W-1:0];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst)
            rdata_q <= '0;
        else if (rd)
            rdata_q <= (sel == SEL_STATUS) ? status_ext : addr_word;
    end

endmodule

// File: rtl/sync_fault_capture.sv
module sync_fault_capture
    import sfc_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flt_valid,
    input  logic [6:0]        flt_cause,
    input  logic [ADDR_W-1:0] flt_addr,
    input  logic              flt_write,
    input  logic              flt_ifetch,
    input  logic              reg_rd,
    input  logic              reg_wr,
    input  logic              reg_sel,
    input  logic [ADDR_W-1:0] reg_wdata,
    output logic [ADDR_W-1:0] reg_rdata,
    output logic              mem_exc
);

    sel_e              sel;
    cause_t            cause_in;
    cause_t            causes_q;
    cause_t            wr_causes;
    logic              hit;
    logic              rd_status;
    logic              wr_status;
    logic              dir_q;
    logic [ADDR_W-1:0] addr_q;
    logic [STAT_W-1:0] status_word;

    always_comb begin
        sel         = sel_e'(reg_sel);
        cause_in    = cause_t'(flt_cause);
        hit         = fault_hit(flt_valid, cause_in);
        rd_status   = reg_rd && !reg_wr && (sel == SEL_STATUS);
        wr_status   = reg_wr && (sel == SEL_STATUS);
        wr_causes   = unpack_causes(reg_wdata[STAT_W-1:0]);
        status_word = pack_status(causes_q, dir_q);
    end

    sfc_cause_acc u_acc (
        .clk       (clk),
        .rst       (rst),
        .hit       (hit),
        .cause_in  (cause_in),
        .clr       (rd_status),
        .wr_en     (wr_status),
        .wr_causes (wr_causes),
        .causes_q  (causes_q)
    );

    sfc_addr_latch #(.ADDR_W(ADDR_W)) u_addr (
        .clk       (clk),
        .rst       (rst),
        .hit       (hit),
        .ifetch    (flt_ifetch),
        .addr_in   (flt_addr),
        .write_in  (flt_write),
        .clr       (rd_status),
        .wr_dir_en (wr_status),
        .wr_dir    (reg_wdata[DIR_POS]),
        .addr_q    (addr_q),
        .dir_q     (dir_q)
    );

    sfc_regport #(.ADDR_W(ADDR_W)) u_port (
        .clk         (clk),
        .rst         (rst),
        .rd          (reg_rd),
        .sel         (sel),
        .status_word (status_word),
        .addr_word   (addr_q),
        .rdata_q     (reg_rdata)
    );

    assign mem_exc = (causes_q != '0);

    // R2: any qualifying fault raises the exception on the next cycle
    a_r2_exc_follows_fault: assert property (@(posedge clk) disable iff (rst)
        hit |=> mem_exc);

    // R12: the exception line is low right after reset
    a_r12_reset_quiet: assert property (@(posedge clk)
        $past(rst) |-> !mem_exc);

endmodule

// File: tb/sync_fault_capture_tb.sv
module sync_fault_capture_tb;

    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst;
    logic          flt_valid;
    logic [6:0]    flt_cause;
    logic [AW-1:0] flt_addr;
    logic          flt_write;
    logic          flt_ifetch;
    logic          reg_rd;
    logic          reg_wr;
    logic          reg_sel;
    logic [AW-1:0] reg_wdata;
    logic [AW-1:0] reg_rdata;
    logic          mem_exc;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    sync_fault_capture #(.ADDR_W(AW)) u_dut (
        .clk(clk), .rst(rst), .flt_valid(flt_valid), .flt_cause(flt_cause),
        .flt_addr(flt_addr), .flt_write(flt_write), .flt_ifetch(flt_ifetch),
        .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_exc(mem_exc)
    );

    task automatic chk(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        flt_valid = 0; flt_cause = '0; flt_addr = '0; flt_write = 0; flt_ifetch = 0;
        reg_rd = 0; reg_wr = 0; reg_sel = 0; reg_wdata = '0;
    endtask

    task automatic fault(input logic [6:0] c, input logic [AW-1:0] a, input logic w, input logic f);
        flt_valid = 1; flt_cause = c; flt_addr = a; flt_write = w; flt_ifetch = f;
        step();
        idle();
    endtask

    task automatic rd(input logic s, output logic [AW-1:0] v);
        reg_rd = 1; reg_sel = s;
        step();
        v = reg_rdata;
        idle();
    endtask

    task automatic wr(input logic s, input logic [AW-1:0] d);
        reg_wr = 1; reg_sel = s; reg_wdata = d;
        step();
        idle();
    endtask

    function automatic logic [AW-1:0] expect_bits(input logic [6:0] c, input logic dir);
        logic [AW-1:0] e = '0;
        e[15] = dir; e[7] = c[6]; e[6] = c[5]; e[5] = c[4];
        e[4] = c[3]; e[3] = c[2]; e[1] = c[1]; e[0] = c[0];
        return e;
    endfunction

    task automatic t_reset();
        logic [AW-1:0] v;
        chk("R12 exc", {31'd0, mem_exc}, 32'd0);
        rd(1'b0, v); chk("R12 status", v, 32'd0);
        rd(1'b1, v); chk("R12 addr", v, 32'd0);
    endtask

    task automatic t_encoding();
        logic [AW-1:0] v;
        for (int i = 0; i < 7; i++) begin
            fault(7'(1 << i), 32'hF000_0100 + 32'(i), 1'b1, 1'b0);
            chk("R2 exc set", {31'd0, mem_exc}, 32'd1);
            rd(1'b0, v);
            chk("R1 R11 encoding", v, expect_bits(7'(1 << i), 1'b1));
            chk("R2 exc cleared", {31'd0, mem_exc}, 32'd0);
            rd(1'b0, v);
            chk("R4 cleared", v, 32'd0);
        end
    endtask

    task automatic t_accumulate();
        logic [AW-1:0] v;
        fault(7'b0010000, 32'hA000_0000, 1'b0, 1'b1);
        fault(7'b0000100, 32'hB000_0004, 1'b0, 1'b0);
        fault(7'b0000001, 32'hB000_0008, 1'b0, 1'b1);
        rd(1'b0, v);
        chk("R3 accumulate", v, expect_bits(7'b0010101, 1'b0));
    endtask

    task automatic t_fetch_after_data();
        logic [AW-1:0] v;
        fault(7'b1000000, 32'hC000_1000, 1'b1, 1'b0);
        fault(7'b0100000, 32'hC000_2000, 1'b0, 1'b1);
        rd(1'b1, v); chk("R5 addr kept", v, 32'hC000_1000);
        rd(1'b0, v); chk("R8 dir with data", v, expect_bits(7'b1100000, 1'b1));
        fault(7'b0100000, 32'hC000_3000, 1'b0, 1'b1);
        rd(1'b1, v); chk("R5 released by read", v, 32'hC000_3000);
        rd(1'b0, v);
    endtask

    task automatic t_data_overwrite();
        logic [AW-1:0] v;
        fault(7'b0001000, 32'hD000_0010, 1'b0, 1'b1);
        fault(7'b0001000, 32'hD000_0020, 1'b0, 1'b0);
        fault(7'b0001000, 32'hD000_0030, 1'b1, 1'b0);
        rd(1'b1, v); chk("R6 latest data", v, 32'hD000_0030);
        rd(1'b0, v); chk("R8 dir write", v, expect_bits(7'b0001000, 1'b1));
        fault(7'b0001000, 32'hD000_0040, 1'b1, 1'b0);
        fault(7'b0001000, 32'hD000_0050, 1'b0, 1'b0);
        rd(1'b0, v); chk("R8 dir read", v, expect_bits(7'b0001000, 1'b0));
    endtask

    task automatic t_fetch_only();
        logic [AW-1:0] v;
        fault(7'b0000010, 32'hE000_0100, 1'b0, 1'b1);
        fault(7'b0000010, 32'hE000_0200, 1'b0, 1'b1);
        rd(1'b1, v); chk("R7 latest fetch", v, 32'hE000_0200);
        rd(1'b0, v);
    endtask

    task automatic t_diag_write();
        logic [AW-1:0] v;
        wr(1'b0, 32'hFFFF_FFFF);
        chk("R9 exc after write", {31'd0, mem_exc}, 32'd1);
        rd(1'b1, v);
        wr(1'b1, 32'h1234_5678);
        rd(1'b1, reg_wdata);
        chk("R9 addr write ignored", reg_wdata, v);
        idle();
        rd(1'b0, v); chk("R9 R11 written status", v, 32'h0000_80FB);
        wr(1'b0, 32'hFFFF_7F04);
        chk("R11 unused no exc", {31'd0, mem_exc}, 32'd0);
        rd(1'b0, v); chk("R11 unused zero", v, 32'd0);
    endtask

    task automatic t_collide();
        logic [AW-1:0] v;
        fault(7'b0001000, 32'h9000_0000, 1'b0, 1'b0);
        reg_rd = 1; reg_sel = 0;
        flt_valid = 1; flt_cause = 7'b0000010; flt_addr = 32'h9000_0044; flt_write = 1; flt_ifetch = 1;
        step();
        v = reg_rdata;
        idle();
        chk("R10 read old", v, expect_bits(7'b0001000, 1'b0));
        chk("R10 exc kept", {31'd0, mem_exc}, 32'd1);
        rd(1'b1, v); chk("R10 addr latched", v, 32'h9000_0044);
        rd(1'b0, v); chk("R10 fault kept", v, expect_bits(7'b0000010, 1'b1));
    endtask

    initial begin
        idle();
        rst = 1;
        step(); step();
        rst = 0;
        t_reset();
        t_encoding();
        t_accumulate();
        t_fetch_after_data();
        t_data_overwrite();
        t_fetch_only();
        t_diag_write();
        t_collide();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #2000000;
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule